// File: doc/BRIEF.md
# Serial Dot-Matrix Scan Controller

This controller refreshes a 128-column by 64-row dot-matrix panel. The panel takes each row through a serial column shift register, holds it in column drivers, and selects the lit row with a row-scan shift chain. For every row the controller reads pixel bits one at a time from an external frame buffer. The buffer has a synchronous read port: the address is presented with a read strobe, and the bit returns on the next clock. The controller clocks each bit into the panel with a dot clock, then latches the finished row into the drivers. It advances the row chain with a row-clock pulse and carries a first-row marker. A display-enable output gates the drivers and also carries a brightness PWM.

One finite-state machine orders every row through a fixed, interlocked sequence. The row period has two parts. In the shift part the enable may be high, under the PWM. In the blanking part the enable is forced low, the latch pulses and the row clock pulses. A row counter runs from 0 to 63 and then wraps, so scanning never stops. The enable stays low after reset until the first row-clock pulse, because the drivers hold no valid row before that pulse.

The states are ST_RESET, ST_FETCH, ST_LOAD, ST_DOT_HI, ST_BLANK, ST_LATCH, ST_RCLK_HI and ST_RCLK_LO. The transitions are:
- ST_RESET→ST_FETCH (start of scan).
- ST_FETCH→ST_LOAD (read issued).
- ST_LOAD→ST_DOT_HI (low phase done).
- ST_DOT_HI→ST_FETCH (more columns).
- ST_DOT_HI→ST_BLANK (column 127 sent).
- ST_BLANK→ST_LATCH (blanking time elapsed).
- ST_LATCH→ST_RCLK_HI (latch pulse done).
- ST_RCLK_HI→ST_RCLK_LO (row clock falls).
- ST_RCLK_LO→ST_FETCH (next row, brightness sampled).

Top module: `dotscan_ctrl`

## Requirements
- R1: Exactly 128 rising edges of `dot_clk` occur between consecutive `col_latch` pulses. Each high phase of `dot_clk` lasts DOT_HALF (2) clocks, and each low phase between two edges of one row lasts at least 2 clocks.
- R2: On the k-th rising edge of `dot_clk` in a row (k counted from 0), `col_data` equals the frame-buffer bit at that row and column k. Columns are sent from 0 upward, and 1 means a lit pixel. `col_data` does not change while `dot_clk` is high.
- R3: `col_latch` is low while bits are shifted. It pulses high for LATCH_CYC (2) clocks once per row, after the 128th dot edge.
- R4: `disp_en` is low on every clock where `col_latch` or `row_clk` changes level.
- R5: Before each `col_latch` rise, `disp_en` has been low for at least BLANK_CYC (500) clocks, which is 10 µs at 50 MHz.
- R6: `row_mark` is high at a falling edge of `row_clk` exactly when the row just latched is row 0. Rows count 0 to 63 and then wrap to 0, so every 64th falling edge carries the marker.
- R7: Over each row period (between two falling edges of `row_clk`), `disp_en` is high for floor(B*640/256) clocks. Here 640 is the shift length (128 columns times 5 clocks), and B is the value of `brightness` when the row-clock low phase ends. B = 0 keeps the display blanked.
- R8: During reset all outputs are low. After reset, `disp_en` stays low until the first falling edge of `row_clk`, whatever the brightness.
- R9: `row_clk` pulses once per row, high for RCLK_CYC (2) clocks and then low for RCLK_CYC clocks, and it keeps running without any input action. `dot_clk`, `col_latch` and `row_clk` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brightness | input | 8 | PWM brightness, sampled at each row start |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_row | output | 6 | Frame-buffer row address |
| fb_col | output | 7 | Frame-buffer column address |
| fb_rdata | input | 1 | Pixel bit, valid the clock after the read strobe |
| dot_clk | output | 1 | Serial shift clock to the panel |
| col_data | output | 1 | Serial column data |
| col_latch | output | 1 | Column driver latch |
| row_clk | output | 1 | Row-scan clock (marker taken on its fall) |
| row_mark | output | 1 | First-row marker |
| disp_en | output | 1 | Driver enable with brightness PWM |

## Verification
A column's read strobe appears one clock before the bit is captured. The captured bit drives `col_data` for the remaining low phase and the two-clock high phase, so the bench compares each pixel at the `dot_clk` rise it sees and needs no fixed delay. The latch rises 500 clocks after the enable drops on column 127. The row clock follows the latch by 2 clocks and falls 2 clocks later. A new brightness is applied on the row-clock rise, before the row-start sampling point 4 clocks later, so each row's enable count belongs to exactly one known value. All outputs are sampled on the falling clock edge, and every check is keyed to the observed edges of `dot_clk`, `col_latch` and `row_clk`, not to absolute cycle numbers.

// File: rtl/dotscan_pkg.sv
package dotscan_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_FETCH,
        ST_LOAD,
        ST_DOT_HI,
        ST_BLANK,
        ST_LATCH,
        ST_RCLK_HI,
        ST_RCLK_LO
    } scan_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dotscan_pos.sv
module dotscan_pos #(
    parameter int unsigned COLS = 128,
    parameter int unsigned ROWS = 64,
    localparam int unsigned CW = $clog2(COLS),
    localparam int unsigned RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_col,
    input  logic          step_row,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row,
    output logic          col_last
);

    localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);
    localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);

    assign col_last = (col == COL_MAX);

    // column pointer: wraps after the last column of a row
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col <= '0;
        end else if (step_col) begin
            col <= col_last ? '0 : col + 1'b1;
        end
    end

    // row pointer: wraps after the last row of a frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step_row) begin
            row <= (row == ROW_MAX) ? '0 : row + 1'b1;
        end
    end

endmodule

// File: rtl/dotscan_pwm.sv
module dotscan_pwm #(
    parameter int unsigned BRIGHT_W  = 8,
    parameter int unsigned SHIFT_LEN = 640,
    localparam int unsigned SW = $clog2(SHIFT_LEN + 1),
    localparam int unsigned PRW = BRIGHT_W + SW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                row_start,
    input  logic                active,
    input  logic [BRIGHT_W-1:0] brightness,
    output logic                pwm_on
);

    localparam logic [SW-1:0] SLEN = SW'(SHIFT_LEN);

    logic [PRW-1:0] prod;
    logic [SW-1:0]  on_len_q;
    logic [SW-1:0]  cnt_q;

    // on-time = brightness * shift length / 2^BRIGHT_W
    assign prod = {{SW{1'b0}}, brightness} * {{BRIGHT_W{1'b0}}, SLEN};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_len_q <= '0;
            cnt_q    <= '0;
        end else if (row_start) begin
            on_len_q <= prod[BRIGHT_W +: SW];
            cnt_q    <= '0;
        end else if (active && cnt_q != {SW{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pwm_on = (cnt_q < on_len_q);

endmodule

// File: rtl/dotscan_fsm.sv
module dotscan_fsm
    import dotscan_pkg::*;
#(
    parameter int unsigned DOT_HALF  = 2,
    parameter int unsigned BLANK_CYC = 500,
    parameter int unsigned LATCH_CYC = 2,
    parameter int unsigned RCLK_CYC  = 2,
    localparam int unsigned MAXL = max2(max2(DOT_HALF, BLANK_CYC), max2(LATCH_CYC, RCLK_CYC)),
    localparam int unsigned PW   = $clog2(MAXL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          col_last,
    output scan_state_t   state,
    output logic [PW-1:0] phase,
    output logic          step_col,
    output logic          step_row,
    output logic          row_start,
    output logic          rclk_fall
);

    localparam logic [PW-1:0] DOT_LIM   = PW'(DOT_HALF - 1);
    localparam logic [PW-1:0] BLANK_LIM = PW'(BLANK_CYC - 1);
    localparam logic [PW-1:0] LATCH_LIM = PW'(LATCH_CYC - 1);
    localparam logic [PW-1:0] RCLK_LIM  = PW'(RCLK_CYC - 1);

    scan_state_t   next_state;
    logic [PW-1:0] limit;
    logic          done;

    // state register with per-state phase timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RESET;
            phase <= '0;
        end else begin
            state <= next_state;
            phase <= (next_state != state) ? '0 : phase + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            ST_LOAD, ST_DOT_HI:     limit = DOT_LIM;
            ST_BLANK:               limit = BLANK_LIM;
            ST_LATCH:               limit = LATCH_LIM;
            ST_RCLK_HI, ST_RCLK_LO: limit = RCLK_LIM;
            default:                limit = '0;
        endcase
    end

    assign done = (phase == limit);

    // transitions and step pulses
    always_comb begin
        next_state = state;
        step_col   = 1'b0;
        step_row   = 1'b0;
        row_start  = 1'b0;
        rclk_fall  = 1'b0;
        unique case (state)
            ST_RESET: begin
                next_state = ST_FETCH;
                row_start  = 1'b1;
            end
            ST_FETCH: begin
                next_state = ST_LOAD;
            end
            ST_LOAD: begin
                if (done) next_state = ST_DOT_HI;
            end
            ST_DOT_HI: begin
                if (done) begin
                    step_col   = 1'b1;
                    next_state = col_last ? ST_BLANK : ST_FETCH;
                end
            end
            ST_BLANK: begin
                if (done) next_state = ST_LATCH;
            end
            ST_LATCH: begin
                if (done) next_state = ST_RCLK_HI;
            end
            ST_RCLK_HI: begin
                if (done) begin
                    next_state = ST_RCLK_LO;
                    rclk_fall  = 1'b1;
                end
            end
            ST_RCLK_LO: begin
                if (done) begin
                    next_state = ST_FETCH;
                    step_row   = 1'b1;
                    row_start  = 1'b1;
                end
            end
            default: next_state = ST_RESET;
        endcase
    end

endmodule

// File: rtl/dotscan_ctrl.sv
module dotscan_ctrl
    import dotscan_pkg::*;
#(
    parameter int unsigned COLS      = 128,
    parameter int unsigned ROWS      = 64,
    parameter int unsigned DOT_HALF  = 2,
    parameter int unsigned BLANK_CYC = 500,
    parameter int unsigned LATCH_CYC = 2,
    parameter int unsigned RCLK_CYC  = 2,
    parameter int unsigned BRIGHT_W  = 8,
    localparam int unsigned CW = $clog2(COLS),
    localparam int unsigned RW = $clog2(ROWS),
    localparam int unsigned SHIFT_LEN = COLS * (2 * DOT_HALF + 1),
    localparam int unsigned MAXL = max2(max2(DOT_HALF, BLANK_CYC), max2(LATCH_CYC, RCLK_CYC)),
    localparam int unsigned PW = $clog2(MAXL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BRIGHT_W-1:0] brightness,
    output logic                fb_rd_en,
    output logic [RW-1:0]       fb_row,
    output logic [CW-1:0]       fb_col,
    input  logic                fb_rdata,
    output logic                dot_clk,
    output logic                col_data,
    output logic                col_latch,
    output logic                row_clk,
    output logic                row_mark,
    output logic                disp_en
);

    scan_state_t   state;
    logic [PW-1:0] phase;
    logic          step_col, step_row, row_start, rclk_fall;
    logic          col_last;
    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic          pwm_on;
    logic          shifting;
    logic          started_q;

    dotscan_fsm #(
        .DOT_HALF  (DOT_HALF),
        .BLANK_CYC (BLANK_CYC),
        .LATCH_CYC (LATCH_CYC),
        .RCLK_CYC  (RCLK_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_last  (col_last),
        .state     (state),
        .phase     (phase),
        .step_col  (step_col),
        .step_row  (step_row),
        .row_start (row_start),
        .rclk_fall (rclk_fall)
    );

    dotscan_pos #(
        .COLS (COLS),
        .ROWS (ROWS)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_col (step_col),
        .step_row (step_row),
        .col      (col),
        .row      (row),
        .col_last (col_last)
    );

    dotscan_pwm #(
        .BRIGHT_W  (BRIGHT_W),
        .SHIFT_LEN (SHIFT_LEN)
    ) u_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_start  (row_start),
        .active     (shifting),
        .brightness (brightness),
        .pwm_on     (pwm_on)
    );

    // pixel capture: read data arrives in the first clock of the low phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_data <= 1'b0;
        end else if (state == ST_LOAD && phase == '0) begin
            col_data <= fb_rdata;
        end
    end

    // drivers stay blanked until the row chain has been clocked once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
        end else if (rclk_fall) begin
            started_q <= 1'b1;
        end
    end

    // output decode from state
    always_comb begin
        fb_rd_en  = 1'b0;
        dot_clk   = 1'b0;
        col_latch = 1'b0;
        row_clk   = 1'b0;
        shifting  = 1'b0;
        row_mark  = 1'b0;
        unique case (state)
            ST_FETCH: begin
                fb_rd_en = 1'b1;
                shifting = 1'b1;
            end
            ST_LOAD: begin
                shifting = 1'b1;
            end
            ST_DOT_HI: begin
                dot_clk  = 1'b1;
                shifting = 1'b1;
            end
            ST_LATCH: begin
                col_latch = 1'b1;
                row_mark  = (row == '0);
            end
            ST_RCLK_HI: begin
                row_clk  = 1'b1;
                row_mark = (row == '0);
            end
            ST_RCLK_LO: begin
                row_mark = (row == '0);
            end
            default: ;
        endcase
    end

    assign fb_row  = row;
    assign fb_col  = col;
    assign disp_en = shifting && started_q && pwm_on;

endmodule

// File: rtl/dotscan_chk.sv
module dotscan_chk (
    input logic clk,
    input logic rst_n,
    input logic dot_clk,
    input logic col_latch,
    input logic row_clk,
    input logic row_mark,
    input logic disp_en,
    input logic fb_rd_en
);

    // R4
    latch_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(col_latch) || $fell(col_latch)) |-> !disp_en);

    // R4
    rclk_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(row_clk) || $fell(row_clk)) |-> !disp_en);

    // R1
    dot_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dot_clk) |=> dot_clk);

    // R1
    dot_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dot_clk) |=> !dot_clk);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dot_clk, col_latch, row_clk, fb_rd_en}));

    // R6
    mark_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_mark |-> (!dot_clk && !disp_en));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_latch) |=> col_latch);

endmodule

bind dotscan_ctrl dotscan_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dot_clk   (dot_clk),
    .col_latch (col_latch),
    .row_clk   (row_clk),
    .row_mark  (row_mark),
    .disp_en   (disp_en),
    .fb_rd_en  (fb_rd_en)
);

// File: tb/dotscan_ctrl_tb.sv
module dotscan_ctrl_tb;

    localparam int COLS = 128, ROWS = 64, DOT_HALF = 2;
    localparam int BLANK_CYC = 500, LATCH_CYC = 2, RCLK_CYC = 2;
    localparam int SHIFT_LEN = COLS * (2 * DOT_HALF + 1);
    localparam int RUN_ROWS = 67;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] brightness = 8'd255;
    logic       fb_rd_en, fb_rdata, dot_clk, col_data, col_latch, row_clk, row_mark, disp_en;
    logic [5:0] fb_row;
    logic [6:0] fb_col;

    int checks = 0, errors = 0;
    bit done = 0;
    bit q[$];

    always #10 clk = ~clk;

    dotscan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .brightness(brightness),
        .fb_rd_en(fb_rd_en), .fb_row(fb_row), .fb_col(fb_col), .fb_rdata(fb_rdata),
        .dot_clk(dot_clk), .col_data(col_data), .col_latch(col_latch),
        .row_clk(row_clk), .row_mark(row_mark), .disp_en(disp_en)
    );

    function automatic bit pix(int r, int c);
        return (((r * 13) + (c * 5) + (c >> 3)) % 3) == 0;
    endfunction

    // frame-buffer model: synchronous one-bit read
    always @(posedge clk) if (fb_rd_en) fb_rdata <= pix(fb_row, fb_col);

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // driver: queue the expected serial stream, row after row
    task automatic push_row(int r);
        for (int c = 0; c < COLS; c++) q.push_back(pix(r, c));
    endtask

    function automatic int on_len(int b);
        return (b * SHIFT_LEN) / 256;
    endfunction

    logic [7:0] bright_tab [8] = '{8'd0, 8'd255, 8'd128, 8'd1, 8'd64, 8'd200, 8'd0, 8'd37};

    // monitor state
    bit p_dot = 0, p_lat = 0, p_rck = 0, dot_val = 0;
    int dots = 0, hi_run = 0, lo_run = 0, lat_run = 0, rck_run = 0;
    int en_low = 0, en_cnt = 0, falls = 0, rises = 0, cur_row = 0;
    int row_b = 0;

    initial begin
        for (int r = 0; r < RUN_ROWS + 1; r++) push_row(r % ROWS);
        repeat (3) @(negedge clk);
        // R8: reset state
        check(!dot_clk && !col_latch && !row_clk && !row_mark && !disp_en && !fb_rd_en && !col_data,
              "R8 reset outputs", {dot_clk, col_latch, row_clk, row_mark, disp_en}, 0);
        rst_n = 1'b1;
    end

    // brightness driver: new value on each row-clock rise
    always @(negedge clk) if (rst_n && row_clk && !p_rck) begin
        brightness <= bright_tab[(rises + 1) % 8];
        rises++;
    end

    always @(negedge clk) if (rst_n && !done) begin
        // dot clock edges and data (R1, R2)
        if (dot_clk && !p_dot) begin
            bit e;
            check(lo_run >= 2 || dots == 0, "R1 dot low width", lo_run, 2);
            if (q.size() == 0) begin
                check(0, "R2 queue underflow", 0, 1);
            end else begin
                e = q.pop_front();
                check(col_data == e, "R2 pixel data", col_data, e);
            end
            dot_val = col_data;
            dots++;
            hi_run = 0;
        end
        if (dot_clk) begin
            hi_run++;
            if (col_data != dot_val) check(0, "R2 data stable while dot high", col_data, dot_val);
            lo_run = 0;
        end else begin
            lo_run++;
        end
        if (!dot_clk && p_dot) check(hi_run == DOT_HALF, "R1 dot high width", hi_run, DOT_HALF);

        // enable bookkeeping (R7)
        if (disp_en) begin
            en_cnt++;
            en_low = 0;
        end else begin
            en_low++;
        end

        // latch (R1, R3, R4, R5)
        if (col_latch && !p_lat) begin
            check(dots == COLS, "R1 dot edges per row", dots, COLS);
            check(en_low > BLANK_CYC, "R5 blanking length", en_low, BLANK_CYC);
            check(!disp_en, "R4 enable low at latch rise", disp_en, 0);
            dots = 0;
            lat_run = 0;
        end
        if (col_latch) begin
            lat_run++;
            if (dot_clk) check(0, "R3 latch during shift", 1, 0);
        end
        if (!col_latch && p_lat) begin
            check(lat_run == LATCH_CYC, "R3 latch width", lat_run, LATCH_CYC);
            check(!disp_en, "R4 enable low at latch fall", disp_en, 0);
        end

        // row clock (R4, R6, R7, R8, R9)
        if (row_clk && !p_rck) begin
            rck_run = 0;
            check(!disp_en, "R4 enable low at row clock rise", disp_en, 0);
        end
        if (row_clk) rck_run++;
        if (!row_clk && p_rck) begin
            check(rck_run == RCLK_CYC, "R9 row clock width", rck_run, RCLK_CYC);
            check(!disp_en, "R4 enable low at row clock fall", disp_en, 0);
            check(row_mark == (cur_row == 0), "R6 row marker", row_mark, cur_row == 0);
            if (falls == 0)
                check(en_cnt == 0, "R8 blanked before first row clock", en_cnt, 0);
            else
                check(en_cnt == on_len(row_b), "R7 enable high time", en_cnt, on_len(row_b));
            row_b = brightness;
            en_cnt = 0;
            falls++;
            cur_row = (cur_row + 1) % ROWS;
            if (falls >= RUN_ROWS) done = 1;
        end

        p_dot = dot_clk;
        p_lat = col_latch;
        p_rck = row_clk;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                check(0, "R9 watchdog expired", falls, RUN_ROWS);
            end
        join_any
        // R6: frame wrap covered by marker check on fall 65
        check(falls >= ROWS + 1 || !done, "R6 rows wrapped", falls, ROWS + 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule